// File: doc/BRIEF.md
# Live Trip-Count Loop Exit Predictor

This block predicts the final iteration of a counted loop from a trip count that the running program supplies, and does not rely only on past behaviour. Software sends the number of iterations still to run and the number of iterations that retire per cycle. It also sends how many cycles the value spent in transit. The block removes the iterations that retired during that transit and then counts down by the per-cycle rate. It raises the exit prediction on the cycle in which the remaining count reaches zero.

While a countdown is armed, its answer replaces the history predictor's answer. The history predictor is represented only by an input bit. When no countdown is armed, that input bit passes straight to the output. A flush disarms the countdown, and a trip count that has already run out by the time it arrives is dropped.

Top module: `live_trip_exit_pred`

## Requirements
- R1: After reset no countdown is armed and `pred_exit` equals `hist_pred_exit`.
- R2: A load is accepted when `load_valid` is 1, `rate` is nonzero and `load_count` is greater than `load_age*rate`. On acceptance the remaining count becomes `load_count - load_age*rate` on the next cycle, and `rate` is captured alongside it.
- R3: While armed with a remaining count greater than the captured rate, the count falls by exactly the captured rate each cycle. The rate may be any value from 1 to 15.
- R4: While armed, `pred_exit` is 1 in the cycle in which the remaining count is at or below the captured rate. The count is clamped to zero and does not wrap, and the countdown disarms on the next cycle.
- R5: While armed with a count above the rate, `pred_exit` is 0 whatever the value of `hist_pred_exit`, so the live count overrides history.
- R6: A load with `load_count <= load_age*rate`, or with `rate == 0`, is ignored, and any countdown already in progress continues unchanged.
- R7: `flush` disarms the countdown on the next cycle and takes priority over a load in the same cycle.
- R8: An accepted load replaces a countdown that is already armed.
- R9: While not armed, `pred_exit` follows `hist_pred_exit` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_valid | input | 1 | Live trip count present this cycle |
| load_count | input | 16 | Iterations remaining when the count was sampled |
| load_age | input | 4 | Cycles the count spent in transit |
| rate | input | 4 | Iterations retired per cycle |
| hist_pred_exit | input | 1 | Exit prediction from the history predictor |
| flush | input | 1 | Drop any armed countdown |
| pred_exit | output | 1 | Predicted loop exit for this cycle |

## Verification
A wrong remaining count is visible only as an exit flag that appears one or more cycles too early or too late. The bench therefore compares `pred_exit` in every cycle against its own model of the countdown, so any slip is reported in the first cycle that differs. A wrong armed state shows up at once, either as the output following `hist_pred_exit` when it should be overridden or the other way round. For this reason the bench toggles the history bit at random throughout the run.

// File: rtl/live_trip_exit_pred.sv
module live_trip_exit_pred #(
  parameter int CW = 16,
  parameter int AW = 4,
  parameter int RW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_valid,
  input  logic [CW-1:0] load_count,
  input  logic [AW-1:0] load_age,
  input  logic [RW-1:0] rate,
  input  logic          hist_pred_exit,
  input  logic          flush,
  output logic          pred_exit
);
  localparam int PW = AW + RW;

  logic          armed_q;
  logic [CW-1:0] cnt_q;
  logic [RW-1:0] rate_q;
  logic [PW-1:0] transit;
  logic [CW:0]   comp;
  logic          accept;
  logic          last;

  assign transit   = PW'(load_age) * PW'(rate);
  assign comp      = {1'b0, load_count} - (CW+1)'(transit);
  assign accept    = load_valid && (rate != '0) && !comp[CW] && (comp != '0);
  assign last      = cnt_q <= CW'(rate_q);
  assign pred_exit = armed_q ? last : hist_pred_exit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
      rate_q  <= '0;
    end else if (flush) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (accept) begin
      armed_q <= 1'b1;
      cnt_q   <= comp[CW-1:0];
      rate_q  <= rate;
    end else if (armed_q) begin
      if (last) begin
        armed_q <= 1'b0;
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_q - CW'(rate_q);
      end
    end
  end
endmodule

module live_trip_exit_pred_chk #(
  parameter int CW = 16,
  parameter int AW = 4,
  parameter int RW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          load_valid,
  input logic [CW-1:0] load_count,
  input logic [AW-1:0] load_age,
  input logic [RW-1:0] rate,
  input logic          hist_pred_exit,
  input logic          flush,
  input logic          pred_exit,
  input logic          armed_q,
  input logic [CW-1:0] cnt_q,
  input logic [RW-1:0] rate_q
);
  logic [CW+AW+RW:0] need;
  logic              good_load;
  assign need      = (CW+AW+RW+1)'(load_age) * (CW+AW+RW+1)'(rate);
  assign good_load = load_valid && rate != '0 && (CW+AW+RW+1)'(load_count) > need;

  assert_follow_hist_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_q |-> pred_exit == hist_pred_exit);
  assert_override_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && cnt_q > CW'(rate_q)) |-> !pred_exit);
  assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && cnt_q > CW'(rate_q) && !flush && !good_load)
      |=> armed_q && cnt_q == $past(cnt_q) - CW'($past(rate_q)));
  assert_exit_disarm_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && pred_exit && !good_load) |=> !armed_q);
  assert_no_zero_armed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |-> cnt_q != '0);
  assert_flush_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !armed_q);
  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (good_load && !flush) |=> armed_q && rate_q == $past(rate)
      && CW'($past(load_count) - CW'($past(need))) == cnt_q);
  assert_reset_R1: assert property (@(posedge clk)
    !rst_n |=> !armed_q);
endmodule

bind live_trip_exit_pred live_trip_exit_pred_chk #(.CW(CW), .AW(AW), .RW(RW)) u_chk (
  .clk(clk), .rst_n(rst_n), .load_valid(load_valid), .load_count(load_count),
  .load_age(load_age), .rate(rate), .hist_pred_exit(hist_pred_exit), .flush(flush),
  .pred_exit(pred_exit), .armed_q(armed_q), .cnt_q(cnt_q), .rate_q(rate_q)
);

// File: tb/tb_live_trip_exit_pred.sv
`timescale 1ns/1ps
module tb_live_trip_exit_pred;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        load_valid = 0;
  logic [15:0] load_count = 0;
  logic [3:0]  load_age = 0;
  logic [3:0]  rate = 0;
  logic        hist_pred_exit = 0;
  logic        flush = 0;
  logic        pred_exit;

  int checks = 0;
  int errors = 0;
  bit m_armed = 0;
  int m_cnt = 0;
  int m_rate = 0;

  always #10 clk = ~clk;

  live_trip_exit_pred dut (.*);

  function automatic bit exp_pred(bit hist);
    if (!m_armed) return hist;
    return m_cnt <= m_rate;
  endfunction

  function automatic bit accepts(bit lv, int cnt, int age, int r);
    return lv && r != 0 && cnt > age * r;
  endfunction

  task automatic check(string req, bit act, bit exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s pred_exit actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(bit lv, int cnt, int age, int r, bit hist, bit fl, string req);
    string tag;
    @(negedge clk);
    load_valid = lv; load_count = cnt[15:0]; load_age = age[3:0];
    rate = r[3:0]; hist_pred_exit = hist; flush = fl;
    #1;
    tag = req;
    if (tag == "") tag = !m_armed ? "R9" : (m_cnt <= m_rate ? "R4" : "R5");
    check(tag, pred_exit, exp_pred(hist));
    if (fl) begin
      m_armed = 0; m_cnt = 0;
    end else if (accepts(lv, cnt, age, r)) begin
      m_armed = 1; m_cnt = cnt - age * r; m_rate = r;
    end else if (m_armed) begin
      if (m_cnt <= m_rate) begin m_armed = 0; m_cnt = 0; end
      else m_cnt = m_cnt - m_rate;
    end
  endtask

  task automatic idle(int n, bit hist, string req);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, hist, 0, req);
  endtask

  initial begin
    #3_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int unused;
    unused = $urandom(32'd1234);
    repeat (3) @(negedge clk);
    rst_n = 1;
    step(0, 0, 0, 0, 1, 0, "R1");
    step(0, 0, 0, 0, 0, 0, "R1");
    // 5 iterations, rate 1: exit on 5th armed cycle, history says continue
    step(1, 5, 0, 1, 1, 0, "R9");
    idle(4, 1, "R5");
    step(0, 0, 0, 0, 0, 0, "R4");
    step(0, 0, 0, 0, 1, 0, "R9");
    // rate 3, count 10: 10,7,4 continue, 1 clamps and exits
    step(1, 10, 0, 3, 0, 0, "R3");
    idle(3, 1, "R3");
    step(0, 0, 0, 0, 0, 0, "R4");
    step(0, 0, 0, 0, 0, 0, "R9");
    // transit compensation: 20 - 3*5 = 5, rate 5 -> exit on first armed cycle
    step(1, 20, 3, 5, 0, 0, "R2");
    step(0, 0, 0, 0, 0, 0, "R2");
    step(0, 0, 0, 0, 0, 0, "R9");
    // exhausted on arrival: 6 <= 2*3, and rate zero
    step(1, 6, 2, 3, 0, 0, "R6");
    step(0, 0, 0, 0, 0, 0, "R6");
    step(1, 9, 0, 0, 1, 0, "R6");
    step(0, 0, 0, 0, 1, 0, "R6");
    // ignored load does not disturb an armed countdown
    step(1, 30, 0, 7, 1, 0, "R8");
    step(1, 4, 1, 4, 1, 0, "R6");
    step(0, 0, 0, 0, 1, 0, "R6");
    // replacement while armed
    step(1, 2, 0, 2, 1, 0, "R8");
    step(0, 0, 0, 0, 0, 0, "R8");
    // flush wins over load
    step(1, 50, 0, 1, 0, 0, "R5");
    step(1, 50, 0, 1, 1, 1, "R7");
    step(0, 0, 0, 0, 1, 0, "R7");
    step(0, 0, 0, 0, 0, 0, "R7");
    // random phase
    for (int i = 0; i < 4000; i++) begin
      bit lv, fl, h;
      int c, a, r;
      lv = ($urandom % 12) == 0;
      fl = ($urandom % 60) == 0;
      h  = $urandom % 2;
      c  = $urandom % 120;
      if (($urandom % 8) == 0) c = 16'hfff0 + $urandom % 16;
      a  = $urandom % 16;
      r  = $urandom % 16;
      step(lv, c, a, r, h, fl, "");
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule